// File: doc/BRIEF.md
# Byte-Masked Data Fuzzing Unit

This block corrupts a wide data word on purpose, for security testing of whatever receives it. A caller presents a 256-bit word and a 32-bit byte-select mask, then pulses a start strobe. One clock later the block returns the word with pseudo-random noise XORed into the selected bytes, together with a one-cycle valid flag. Bytes whose mask bit is clear pass through untouched. Fixed fields such as addresses or checksums can therefore be kept intact while the rest of the word is corrupted.

The noise comes from 32 narrow 8-bit linear congruential generators that run side by side, each with its own constant pair. A first stage mixes each lane's state with a rotated copy of its neighbour's state. A second stage places the mixed bytes side by side to form the 256-bit noise word. The generators step once for each accepted request. A synchronous seed load sets every lane to a known value, so a run can be replayed.

Top module: `byte_fuzz_unit`

## Requirements
- R1: While rst_n is low and after its release, valid_o is 0 and data_o is all zeros. Each lane k (0..31) holds the state value k.
- R2: Mask bit i selects byte i of the word, which is bits 8i+7 down to 8i. Bit 0 therefore covers the least significant byte.
- R3: A start_i pulse with seed_load_i low is an accepted request. In the following cycle, data_o equals data_i XOR (expanded mask AND noise word), and valid_o is 1 for exactly that one cycle. Both data_i and mask_i are sampled at the request.
- R4: A byte whose mask bit is 0 appears on data_o exactly as it was on data_i. An all-zero mask returns the input unchanged.
- R5: Byte k of the noise word is s_k XOR rotl3(s_((k+1) mod 32)). Here s_k is lane k's state at the request, and rotl3 is an 8-bit rotate left by 3 places.
- R6: On each step, lane k moves to (a_k * s_k + c_k) mod 256, where a_k = (8k + 5) mod 256 and c_k = (2k + 1) mod 256.
- R7: The lane states step only on an accepted request. In idle cycles they hold their values.
- R8: seed_load_i sets every lane to seed_i on the next edge. A start_i in the same cycle is ignored: valid_o stays 0, data_o holds its value, and no step is taken.
- R9: data_o holds its last result in every cycle with no accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, one cycle per word |
| data_i | input | 256 | Word to corrupt |
| mask_i | input | 32 | Byte-select mask, one bit per byte |
| seed_load_i | input | 1 | Load seed_i into every lane |
| seed_i | input | 8 | Seed value |
| data_o | output | 256 | Fuzzed word |
| valid_o | output | 1 | Result valid, one cycle |

## Verification
The fuzzed word and valid_o are due on the first rising edge after an accepted request. A seed load takes effect on the first edge after it, so the noise it produces shows up one request later.

The bench drives inputs on falling edges and reads outputs on the next falling edge. This puts every read half a cycle after the single register stage that produces the result. A bench model of the 32 lanes steps only when the bench issues an accepted request. Idle gaps and ignored strobes therefore show up as mismatches if the design steps when it should not.

// File: rtl/byte_fuzz_pkg.sv
package byte_fuzz_pkg;
  localparam int LANE_W = 8;
  localparam int ROT    = 3;
  typedef logic [LANE_W-1:0] lane_t;

  function automatic lane_t lane_mult(input int idx);
    lane_t m;
    m = lane_t'(8 * idx + 5);
    return m;
  endfunction

  function automatic lane_t lane_incr(input int idx);
    lane_t c;
    c = lane_t'(2 * idx + 1);
    return c;
  endfunction

  function automatic lane_t lcg_step(input lane_t s, input lane_t a, input lane_t c);
    lane_t prod;
    prod = a * s;
    return prod + c;
  endfunction

  function automatic lane_t rotl(input lane_t x, input int r);
    lane_t y;
    y = (x << r) | (x >> (LANE_W - r));
    return y;
  endfunction
endpackage

// File: rtl/byte_fuzz_lane.sv
module byte_fuzz_lane
  import byte_fuzz_pkg::*;
#(
  parameter int LANE_IDX = 0
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  step_i,
  input  logic  load_i,
  input  lane_t seed_i,
  output lane_t state_o
);
  localparam lane_t MULT  = lane_mult(LANE_IDX);
  localparam lane_t INCR  = lane_incr(LANE_IDX);
  localparam lane_t RESET = lane_t'(LANE_IDX);

  lane_t state_q;
  lane_t next_w;

  assign next_w = lcg_step(state_q, MULT, INCR);

  always_ff @(posedge clk) begin
    if (!rst_n)      state_q <= RESET;
    else if (load_i) state_q <= seed_i;
    else if (step_i) state_q <= next_w;
  end

  assign state_o = state_q;
endmodule

// File: rtl/byte_fuzz_mixer.sv
module byte_fuzz_mixer
  import byte_fuzz_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic [LANES*LANE_W-1:0] lanes_i,
  output logic [LANES*LANE_W-1:0] noise_o
);
  // stage one: neighbour mix; stage two: byte-wise concatenation
  for (genvar k = 0; k < LANES; k++) begin : g_mix
    localparam int NB = (k + 1) % LANES;
    lane_t own_w, nb_w;
    assign own_w = lanes_i[k*LANE_W +: LANE_W];
    assign nb_w  = lanes_i[NB*LANE_W +: LANE_W];
    assign noise_o[k*LANE_W +: LANE_W] = own_w ^ rotl(nb_w, ROT);
  end
endmodule

// File: rtl/byte_fuzz_apply.sv
module byte_fuzz_apply
  import byte_fuzz_pkg::*;
#(
  parameter int LANES = 32
) (
  input  logic [LANES*LANE_W-1:0] data_i,
  input  logic [LANES-1:0]        mask_i,
  input  logic [LANES*LANE_W-1:0] noise_i,
  output logic [LANES*LANE_W-1:0] expand_o,
  output logic [LANES*LANE_W-1:0] result_o
);
  for (genvar i = 0; i < LANES; i++) begin : g_exp
    assign expand_o[i*LANE_W +: LANE_W] = {LANE_W{mask_i[i]}};
  end
  assign result_o = data_i ^ (expand_o & noise_i);
endmodule

// File: rtl/byte_fuzz_unit.sv
module byte_fuzz_unit
  import byte_fuzz_pkg::*;
#(
  parameter int DATA_W = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [DATA_W/8-1:0] mask_i,
  input  logic              seed_load_i,
  input  logic [7:0]        seed_i,
  output logic [DATA_W-1:0] data_o,
  output logic              valid_o
);
  localparam int LANES = DATA_W / LANE_W;

  logic              accept_w;
  logic [DATA_W-1:0] lane_state;
  logic [DATA_W-1:0] noise_w;
  logic [DATA_W-1:0] expand_w;
  logic [DATA_W-1:0] result_w;
  logic [DATA_W-1:0] data_q;
  logic              valid_q;

  assign accept_w = start_i & ~seed_load_i;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    byte_fuzz_lane #(.LANE_IDX(k)) lane_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_i  (accept_w),
      .load_i  (seed_load_i),
      .seed_i  (seed_i),
      .state_o (lane_state[k*LANE_W +: LANE_W])
    );
  end

  byte_fuzz_mixer #(.LANES(LANES)) mixer_i (
    .lanes_i (lane_state),
    .noise_o (noise_w)
  );

  byte_fuzz_apply #(.LANES(LANES)) apply_i (
    .data_i   (data_i),
    .mask_i   (mask_i),
    .noise_i  (noise_w),
    .expand_o (expand_w),
    .result_o (result_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= accept_w;
      if (accept_w) data_q <= result_w;
    end
  end

  assign data_o  = data_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/byte_fuzz_unit_chk.sv
module byte_fuzz_unit_chk #(
  parameter int DATA_W = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              seed_load_i,
  input logic [DATA_W-1:0] data_i,
  input logic [DATA_W/8-1:0] mask_i,
  input logic [DATA_W-1:0] data_o,
  input logic              valid_o,
  input logic [DATA_W-1:0] lane_state,
  input logic [DATA_W-1:0] expand_w
);
  assert_valid_after_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !seed_load_i) |=> valid_o);

  assert_valid_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_i && !seed_load_i) |=> !valid_o);

  assert_unmasked_pass_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !seed_load_i) |=> ((data_o ^ $past(data_i)) & ~$past(expand_w)) == '0);

  assert_lsb_byte_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !seed_load_i && !mask_i[0]) |=> data_o[7:0] == $past(data_i[7:0]));

  assert_state_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && !seed_load_i) |=> $stable(lane_state));

  assert_seed_blocks_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load_i |=> (!valid_o && $stable(data_o)));

  assert_output_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(data_o));
endmodule

bind byte_fuzz_unit byte_fuzz_unit_chk #(.DATA_W(DATA_W)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .seed_load_i (seed_load_i),
  .data_i      (data_i),
  .mask_i      (mask_i),
  .data_o      (data_o),
  .valid_o     (valid_o),
  .lane_state  (lane_state),
  .expand_w    (expand_w)
);

// File: tb/byte_fuzz_unit_tb_top.sv
module byte_fuzz_unit_tb_top;
  localparam int DW = 256;
  localparam int NL = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [DW-1:0] data_i = '0;
  logic [NL-1:0] mask_i = '0;
  logic          seed_load_i = 1'b0;
  logic [7:0]    seed_i = '0;
  logic [DW-1:0] data_o;
  logic          valid_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] st [NL];

  // {mask, 32-bit data pattern repeated eight times}
  localparam logic [63:0] VEC [8] = '{
    64'hFFFF_FFFF_0000_0000, 64'h0000_0000_DEAD_BEEF,
    64'h0000_0001_FFFF_FFFF, 64'h8000_0000_1234_5678,
    64'h0F0F_0F0F_A5A5_A5A5, 64'hF0F0_F0F0_5A5A_5A5A,
    64'h0000_FFFF_0BAD_F00D, 64'h5555_5555_C3C3_C3C3
  };

  always #10 clk = ~clk;

  byte_fuzz_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i),
    .mask_i(mask_i), .seed_load_i(seed_load_i), .seed_i(seed_i),
    .data_o(data_o), .valid_o(valid_o)
  );

  function automatic logic [DW-1:0] model_noise();
    logic [DW-1:0] n;
    for (int k = 0; k < NL; k++) begin
      logic [7:0] nb;
      nb = st[(k + 1) % NL];
      n[k*8 +: 8] = st[k] ^ {nb[4:0], nb[7:5]};
    end
    return n;
  endfunction

  task automatic model_step();
    for (int k = 0; k < NL; k++) begin
      logic [15:0] p;
      p = 16'(8 * k + 5) * 16'(st[k]) + 16'(2 * k + 1);
      st[k] = p[7:0];
    end
  endtask

  function automatic logic [DW-1:0] model_fuzz(input logic [DW-1:0] d, input logic [NL-1:0] m);
    logic [DW-1:0] n, r;
    n = model_noise();
    r = d;
    for (int b = 0; b < NL; b++)
      if (m[b]) r[b*8 +: 8] = d[b*8 +: 8] ^ n[b*8 +: 8];
    return r;
  endfunction

  task automatic check_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic check_word(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fuzz(input string req, input logic [DW-1:0] d, input logic [NL-1:0] m);
    logic [DW-1:0] exp;
    exp = model_fuzz(d, m);
    model_step();
    data_i = d; mask_i = m; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check_bit(req, valid_o, 1'b1);
    check_word(req, data_o, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] held;
    for (int k = 0; k < NL; k++) st[k] = 8'(k);
    repeat (3) @(negedge clk);
    check_bit("R1 valid in reset", valid_o, 1'b0);
    check_word("R1 data in reset", data_o, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check_bit("R1 valid after reset", valid_o, 1'b0);

    // R1 R5 R6: first request uses reset lane states
    fuzz("R1 R5 first request", '0, '1);

    for (int v = 0; v < 8; v++) begin
      fuzz("R3 R6 vector", {8{VEC[v][31:0]}}, VEC[v][63:32]);
    end

    // R3: valid lasts one cycle; R7 R9: idle gap
    held = data_o;
    @(negedge clk);
    check_bit("R3 valid drops", valid_o, 1'b0);
    data_i = '1; mask_i = '1;
    repeat (4) @(negedge clk);
    check_word("R9 output held", data_o, held);
    fuzz("R7 no step while idle", {8{32'h0F1E_2D3C}}, '1);

    // R4: zero mask passes data
    fuzz("R4 zero mask", {8{32'hCAFE_1234}}, '0);
    check_word("R4 passthrough", data_o, {8{32'hCAFE_1234}});

    // R2: single mask bit touches only its byte
    fuzz("R2 byte 5", '0, 32'h0000_0020);
    check_word("R2 other bytes zero", data_o & ~(256'hFF << 40), '0);

    // R8: seed load, then seed with start in same cycle
    seed_i = 8'hA7; seed_load_i = 1'b1;
    @(negedge clk);
    seed_load_i = 1'b0;
    for (int k = 0; k < NL; k++) st[k] = 8'hA7;
    held = data_o;
    seed_i = 8'h3C; seed_load_i = 1'b1; start_i = 1'b1; data_i = '1; mask_i = '1;
    @(negedge clk);
    seed_load_i = 1'b0; start_i = 1'b0;
    for (int k = 0; k < NL; k++) st[k] = 8'h3C;
    check_bit("R8 start ignored", valid_o, 1'b0);
    check_word("R8 data held", data_o, held);
    fuzz("R8 R5 seeded noise", '0, '1);
    fuzz("R6 seeded step", {8{32'h1357_9BDF}}, 32'hFFFF_FFFF);

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule